// File: doc/BRIEF.md
# Write Protection and Status Unit

This block sits between the command decoder of a serial nonvolatile memory and its storage array. It owns the status byte. That byte holds a write-in-progress flag, a write enable latch and two block-protect bits. The block decides whether a requested array or status write may go ahead. When a write is allowed, it issues a single program strobe to the array and then runs a self-timed write cycle, during which it reports busy.

The command decoder hands the block one-cycle strobes. These are set-latch, clear-latch, array write commit (with its page address) and status write commit (with its data byte). A write is accepted only when four conditions all hold: the latch is set, the write-protect pin is high, no cycle is running, and, for array writes, the address lies outside the range chosen by the protect bits. When a cycle completes, the latch clears. A synchronous power-on reset clears the latch and any running cycle but keeps the protect bits, which models their nonvolatile storage.

Top module: `wp_status_unit`

## Requirements
- R1: After the asynchronous reset, status_byte is 0x00, busy is 0 and prog_strobe is 0.
- R2: The status byte layout is: bit 0 write-in-progress, bit 1 write enable latch, bit 3:2 protect bits (bit 3 high), bits 7:4 read 0 when idle. cmd_wren sets bit 1 and cmd_wrdi clears it. If both arrive in one cycle, clear wins.
- R3: A commit made while the latch is clear is dropped: busy and prog_strobe stay 0.
- R4: The protect bits map to protected ranges as follows: 00 protects nothing, 01 protects 0xC0-0xFF, 10 protects 0x80-0xFF, 11 protects 0x00-0xFF. An array commit to a protected address is refused without a cycle, and the latch stays set.
- R5: While wp_n is low, every commit is refused and the latch is unchanged. wp_n falling after a cycle has started does not shorten that cycle.
- R6: An accepted array commit raises prog_strobe for exactly one cycle, in the first busy cycle, with prog_addr equal to commit_addr. busy then stays high for exactly WR_CYCLES cycles.
- R7: While busy is high, status_byte reads 0xFF.
- R8: When a write cycle completes, the latch is cleared.
- R9: A status commit changes only the protect bits, taking them from status_data bits 3:2. The new value is visible once the cycle ends, and all other data bits are ignored.
- R10: por clears the latch and aborts a running cycle on the next edge, and leaves the protect bits unchanged.
- R11: While busy, cmd_wren, cmd_wrdi and commits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all state |
| por | input | 1 | Synchronous power-up event, keeps protect bits |
| cmd_wren | input | 1 | Set write enable latch strobe |
| cmd_wrdi | input | 1 | Clear write enable latch strobe |
| commit_array | input | 1 | Array write commit request |
| commit_addr | input | ADDR_W | Page address of the array write |
| commit_status | input | 1 | Status write commit request |
| status_data | input | DATA_W | Data byte of the status write |
| wp_n | input | 1 | Write-protect pin, low refuses writes |
| status_byte | output | DATA_W | Status byte read-back |
| busy | output | 1 | Self-timed write cycle running |
| prog_strobe | output | 1 | One-cycle program pulse to the array |
| prog_addr | output | ADDR_W | Address accompanying prog_strobe |

## Verification
The bench walks the edges of each protect range. It tests the first protected address and the last free one for every protect setting. A decoder that is off by one quarter, or that reads the protect bits in the wrong order, would start a cycle where none is allowed. The bench also lowers wp_n in the middle of a cycle and checks that busy keeps its full length. It issues set-latch and extra commits during a cycle and checks that the latch still reads clear afterwards and that no second strobe appears. Finally, it applies por and checks that the protect bits survive while the cycle stops, which catches a design that ties the protect bits to the same reset as the latch.

// File: rtl/wps_pkg.sv
package wps_pkg;
  localparam int WIP_POS = 0;
  localparam int WEL_POS = 1;
  localparam int BP_LO   = 2;
  localparam int BP_W    = 2;
endpackage

// File: rtl/protect_map.sv
module protect_map #(
  parameter int ADDR_W = 8
) (
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              prot
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    unique case (bp)
      2'b00:   prot = 1'b0;
      2'b01:   prot = addr[TOP] & addr[TOP-1];
      2'b10:   prot = addr[TOP];
      default: prot = 1'b1;
    endcase
  end
endmodule

// File: rtl/wr_timer.sv
module wr_timer #(
  parameter int CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic active,
  output logic done
);
  localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign active = act_q;
  assign done   = act_q && (cnt_q == '0);

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (clr) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (start && !act_q) begin
      act_d = 1'b1;
      cnt_d = LOAD;
    end else if (act_q) begin
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  // R6
  cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cnt_q != '0 && !clr) |=> act_q);
  // R6
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !start) |=> !act_q);
endmodule

// File: rtl/wp_status_unit.sv
module wp_status_unit #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              commit_array,
  input  logic [ADDR_W-1:0] commit_addr,
  input  logic              commit_status,
  input  logic [DATA_W-1:0] status_data,
  input  logic              wp_n,
  output logic [DATA_W-1:0] status_byte,
  output logic              busy,
  output logic              prog_strobe,
  output logic [ADDR_W-1:0] prog_addr
);
  import wps_pkg::*;

  localparam int HI_W = DATA_W - BP_LO - BP_W;

  logic              wel_q, wel_d;
  logic [BP_W-1:0]   bp_q, bp_d, pend_q, pend_d;
  logic              isst_q, isst_d;
  logic              strb_q, strb_d;
  logic [ADDR_W-1:0] paddr_q, paddr_d;
  logic              prot, done, allow, acc_arr, acc_st, start;

  protect_map #(.ADDR_W(ADDR_W)) u_map (
    .bp   (bp_q),
    .addr (commit_addr),
    .prot (prot)
  );

  wr_timer #(.CYCLES(WR_CYCLES)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (por),
    .start  (start),
    .active (busy),
    .done   (done)
  );

  assign allow   = wel_q && wp_n && !busy && !por;
  assign acc_arr = allow && commit_array && !prot;
  assign acc_st  = allow && commit_status && !commit_array;
  assign start   = acc_arr || acc_st;

  always_comb begin
    wel_d   = wel_q;
    bp_d    = bp_q;
    pend_d  = pend_q;
    isst_d  = isst_q;
    paddr_d = paddr_q;
    strb_d  = 1'b0;
    if (por) begin
      wel_d  = 1'b0;
      isst_d = 1'b0;
    end else if (done) begin
      wel_d  = 1'b0;
      isst_d = 1'b0;
      if (isst_q) bp_d = pend_q;
    end else if (!busy) begin
      if (cmd_wrdi)      wel_d = 1'b0;
      else if (cmd_wren) wel_d = 1'b1;
      if (start) begin
        strb_d  = acc_arr;
        isst_d  = acc_st;
        paddr_d = commit_addr;
        pend_d  = status_data[BP_LO +: BP_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q   <= 1'b0;
      bp_q    <= '0;
      pend_q  <= '0;
      isst_q  <= 1'b0;
      strb_q  <= 1'b0;
      paddr_q <= '0;
    end else begin
      wel_q   <= wel_d;
      bp_q    <= bp_d;
      pend_q  <= pend_d;
      isst_q  <= isst_d;
      strb_q  <= strb_d;
      paddr_q <= paddr_d;
    end
  end

  assign prog_strobe = strb_q;
  assign prog_addr   = paddr_q;
  assign status_byte = busy ? {DATA_W{1'b1}}
                            : {{HI_W{1'b0}}, bp_q, wel_q, 1'b0};

  // R6
  strobe_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_strobe |-> busy);
  // R3
  start_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel_q));
  // R5
  start_needs_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wp_n));
  // R4
  strobe_unprotected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_strobe |-> !$past(prot));
  // R8
  latch_clear_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel_q);
  // R10
  por_keeps_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(por) |-> bp_q == $past(bp_q));
endmodule

// File: tb/tb_wp_status_unit.sv
module tb_wp_status_unit;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n, por, cmd_wren, cmd_wrdi, commit_array, commit_status, wp_n;
  logic [7:0] commit_addr, status_data, status_byte, prog_addr;
  logic       busy, prog_strobe;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  wp_status_unit #(.ADDR_W(8), .DATA_W(8), .WR_CYCLES(N)) dut (
    .clk(clk), .rst_n(rst_n), .por(por), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .commit_array(commit_array), .commit_addr(commit_addr),
    .commit_status(commit_status), .status_data(status_data), .wp_n(wp_n),
    .status_byte(status_byte), .busy(busy), .prog_strobe(prog_strobe),
    .prog_addr(prog_addr)
  );

  // {bp[1:0], addr[7:0], accepted}
  localparam logic [10:0] VEC [8] = '{
    {2'b00, 8'hFF, 1'b1}, {2'b01, 8'hBF, 1'b1}, {2'b01, 8'hC0, 1'b0},
    {2'b10, 8'h7F, 1'b1}, {2'b10, 8'h80, 1'b0}, {2'b11, 8'h00, 1'b0},
    {2'b01, 8'hFF, 1'b0}, {2'b00, 8'h00, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wren();
    @(negedge clk) cmd_wren = 1'b1;
    @(negedge clk) cmd_wren = 1'b0;
  endtask

  task automatic wrdi();
    @(negedge clk) cmd_wrdi = 1'b1;
    @(negedge clk) cmd_wrdi = 1'b0;
  endtask

  task automatic put_arr(input logic [7:0] a);
    @(negedge clk) begin commit_array = 1'b1; commit_addr = a; end
    @(negedge clk) commit_array = 1'b0;
  endtask

  task automatic put_st(input logic [7:0] d);
    @(negedge clk) begin commit_status = 1'b1; status_data = d; end
    @(negedge clk) commit_status = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic set_bp(input logic [1:0] b);
    wren();
    put_st({4'hA, b, 2'b11});
    wait_idle();
  endtask

  initial begin
    rst_n = 1'b0; por = 1'b0; cmd_wren = 1'b0; cmd_wrdi = 1'b0;
    commit_array = 1'b0; commit_status = 1'b0; commit_addr = '0;
    status_data = '0; wp_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", status_byte, 8'h00);
    chk("R1 busy", busy, 0);
    chk("R1 strobe", prog_strobe, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 latch set, clear, clear wins
    wren();
    chk("R2 wren", status_byte, 8'h02);
    wrdi();
    chk("R2 wrdi", status_byte, 8'h00);
    wren();
    @(negedge clk) begin cmd_wren = 1'b1; cmd_wrdi = 1'b1; end
    @(negedge clk) begin cmd_wren = 1'b0; cmd_wrdi = 1'b0; end
    chk("R2 both", status_byte, 8'h00);

    // R3 dropped without latch
    put_arr(8'h10);
    chk("R3 busy", busy, 0);
    chk("R3 strobe", prog_strobe, 0);

    // R4 R9 protect map table walk
    for (int i = 0; i < 8; i++) begin
      logic [1:0] b;
      logic [7:0] a;
      logic       acc;
      {b, a, acc} = VEC[i];
      set_bp(b);
      // R9 only bits 3:2 taken, latch cleared after cycle
      chk("R9 bp", status_byte, {4'h0, b, 2'b00});
      wren();
      put_arr(a);
      chk("R4 busy", busy, acc);
      chk("R4 strobe", prog_strobe, acc);
      if (acc) begin
        chk("R6 addr", prog_addr, a);
        wait_idle();
      end else begin
        chk("R4 latch kept", status_byte, {4'h0, b, 2'b10});
        wrdi();
      end
    end
    set_bp(2'b00);

    // R6 R7 R8 strobe width, busy length, status read-back
    begin
      int cnt;
      wren();
      put_arr(8'h42);
      chk("R7 ff", status_byte, 8'hFF);
      chk("R6 strobe", prog_strobe, 1);
      cnt = 1;
      @(negedge clk);
      chk("R6 strobe one", prog_strobe, 0);
      while (busy) begin cnt++; @(negedge clk); end
      chk("R6 length", cnt, N);
      chk("R8 latch clear", status_byte, 8'h00);
    end

    // R5 pin low refuses, latch unchanged
    wren();
    wp_n = 1'b0;
    put_arr(8'h05);
    chk("R5 refused", busy, 0);
    put_st(8'h0C);
    chk("R5 refused st", busy, 0);
    chk("R5 latch", status_byte, 8'h02);
    wp_n = 1'b1;

    // R5 pin falls mid cycle
    begin
      int cnt;
      put_arr(8'h06);
      cnt = 1;
      @(negedge clk) wp_n = 1'b0;
      cnt++;
      while (busy) begin @(negedge clk); if (busy) cnt++; end
      chk("R5 mid cycle", cnt, N);
      wp_n = 1'b1;
    end

    // R11 commands during cycle ignored
    begin
      int strobes;
      wren();
      put_arr(8'h07);
      strobes = 0;
      @(negedge clk) cmd_wren = 1'b1;
      @(negedge clk) begin cmd_wren = 1'b0; commit_array = 1'b1; commit_addr = 8'h08; end
      @(negedge clk) commit_array = 1'b0;
      while (busy) begin if (prog_strobe) strobes++; @(negedge clk); end
      chk("R11 no strobe", strobes, 0);
      chk("R11 latch", status_byte, 8'h00);
    end

    // R10 por keeps bp, aborts cycle
    set_bp(2'b10);
    wren();
    put_arr(8'h11);
    chk("R10 started", busy, 1);
    @(negedge clk) por = 1'b1;
    @(negedge clk) por = 1'b0;
    chk("R10 abort", busy, 0);
    chk("R10 bp kept", status_byte, 8'h08);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule